// File: doc/BRIEF.md
# Three-Leg Shoot-Through Interlock

This block conditions the gate commands of a three-phase half-bridge inverter. Each phase leg has a high-side and a low-side command input and a matching gate-enable output. The block makes sure that the two switches of one leg are never enabled together. When both commands of a leg overlap, the side that was granted first keeps the leg, and the late side waits.

Every time a gate of a leg turns off, both gates of that leg stay off for a programmable number of clock cycles before either may turn on. A global kill input, driven by a fault block in the same clock domain, forces every gate off on the next cycle. After the kill is released, each leg waits out a full dead time. The command inputs are asynchronous and pass through a two-flop synchronizer. Each leg is a small three-state machine (off, high on, low on) that owns a dead-time down-counter.

Top module: `gate_interlock`

## Requirements
- R1: While `rst_n` is low, all gate outputs are low. After reset is released, a leg drives no gate until `DEAD_CYC` rising clock edges have passed.
- R2: For every leg, `gate_hi[i]` and `gate_lo[i]` are never high in the same cycle.
- R3: Commands are sampled through two flops. A leg that is off and past its dead time turns the commanded gate on at the third rising edge after the command changes.
- R4: While one gate of a leg is on, a command to the other side of that leg is ignored: the other gate stays low, and the active gate stays on for as long as its own command holds.
- R5: If both synchronized commands of an idle leg rise in the same cycle, neither gate turns on. When one command drops, the remaining side turns on three edges later.
- R6: A gate turns off at the third rising edge after its command drops. From then on, both gates of the leg stay low for exactly `DEAD_CYC` cycles. A blocked command that is still asserted then turns its gate on at the `DEAD_CYC`-th edge after the fall.
- R7: A command that drops and comes back on the same side also waits the full dead time before its gate turns on again.
- R8: A high `global_off` drives all gate outputs low after the next rising edge and holds them low. After release, each leg waits `DEAD_CYC` edges, counted from the last edge at which `global_off` was high, before it turns a gate on.
- R9: The legs are independent. For any combination of commands applied together to idle legs, leg i drives `gate_hi[i]` only when its high command alone is set, and drives `gate_lo[i]` only when its low command alone is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | NUM_LEGS | High-side commands, bit i for leg i, asynchronous |
| cmd_lo | input | NUM_LEGS | Low-side commands, bit i for leg i, asynchronous |
| global_off | input | 1 | Synchronous kill of all gates, active high |
| gate_hi | output | NUM_LEGS | High-side gate enables |
| gate_lo | output | NUM_LEGS | Low-side gate enables |

## Verification
The bench builds the block with three legs and `DEAD_CYC` set to 4. With these values every dead-time window, and the edge where it closes, falls within a few cycles of directed stimulus, so the exact cycle of each gate edge can be checked. The small leg count makes it possible to sweep all 64 combinations of the six command bits from an idle state. Handover in both directions, re-assertion on the same side, simultaneous requests and kill release are each checked at the boundary edge and at the edge just before it.

// File: rtl/gate_interlock_pkg.sv
package gate_interlock_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_state_e;

  // counter width able to hold dead-time reload value (dead - 1)
  function automatic int unsigned dead_cnt_w(input int unsigned dead);
    return (dead < 3) ? 1 : $clog2(dead);
  endfunction

  // which side may be granted from an idle leg: only a lone request wins
  function automatic leg_state_e grant_pick(input logic req_h, input logic req_l);
    if (req_h && !req_l) return LEG_HI;
    if (req_l && !req_h) return LEG_LO;
    return LEG_OFF;
  endfunction

endpackage

// File: rtl/cdc_sync2.sv
module cdc_sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end

endmodule

// File: rtl/dead_timer.sv
module dead_timer #(
  parameter int unsigned DEAD_CYC = 38,
  localparam int unsigned CNT_W   = gate_interlock_pkg::dead_cnt_w(DEAD_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic expired
);

  localparam logic [CNT_W-1:0] RELOAD_VAL = CNT_W'(DEAD_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RELOAD_VAL;
    end else if (reload) begin
      cnt <= RELOAD_VAL;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/leg_arbiter.sv
module leg_arbiter
  import gate_interlock_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic req_hi,
  input  logic req_lo,
  output logic gate_hi,
  output logic gate_lo,
  output logic fall_evt
);

  leg_state_e state, state_nxt;
  logic       dt_expired;
  logic       dt_reload;

  always_comb begin
    state_nxt = state;
    unique case (state)
      LEG_OFF: if (dt_expired) state_nxt = grant_pick(req_hi, req_lo);
      LEG_HI:  if (!req_hi)    state_nxt = LEG_OFF;
      LEG_LO:  if (!req_lo)    state_nxt = LEG_OFF;
      default:                 state_nxt = LEG_OFF;
    endcase
    if (kill) state_nxt = LEG_OFF;
  end

  assign fall_evt  = (state != LEG_OFF) && (state_nxt == LEG_OFF);
  assign dt_reload = kill | fall_evt;

  dead_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (dt_reload),
    .expired (dt_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LEG_OFF;
    else        state <= state_nxt;
  end

  assign gate_hi = (state == LEG_HI);
  assign gate_lo = (state == LEG_LO);

endmodule

// File: rtl/gate_interlock.sv
module gate_interlock #(
  parameter int unsigned NUM_LEGS = 3,
  parameter int unsigned DEAD_CYC = 38
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LEGS-1:0] cmd_hi,
  input  logic [NUM_LEGS-1:0] cmd_lo,
  input  logic                global_off,
  output logic [NUM_LEGS-1:0] gate_hi,
  output logic [NUM_LEGS-1:0] gate_lo
);

  localparam int unsigned SYNC_W = 2 * NUM_LEGS;

  logic [NUM_LEGS-1:0] sync_hi;
  logic [NUM_LEGS-1:0] sync_lo;
  logic [NUM_LEGS-1:0] leg_fall;

  cdc_sync2 #(.WIDTH(SYNC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({cmd_lo, cmd_hi}),
    .q_sync  ({sync_lo, sync_hi})
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    leg_arbiter #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (global_off),
      .req_hi   (sync_hi[g]),
      .req_lo   (sync_lo[g]),
      .gate_hi  (gate_hi[g]),
      .gate_lo  (gate_lo[g]),
      .fall_evt (leg_fall[g])
    );
  end

endmodule

// File: rtl/gate_interlock_chk.sv
module gate_interlock_chk #(
  parameter int unsigned NUM_LEGS = 3,
  parameter int unsigned DEAD_CYC = 38
) (
  input logic                clk,
  input logic                rst_n,
  input logic                global_off,
  input logic [NUM_LEGS-1:0] sync_hi,
  input logic [NUM_LEGS-1:0] sync_lo,
  input logic [NUM_LEGS-1:0] leg_fall,
  input logic [NUM_LEGS-1:0] gate_hi,
  input logic [NUM_LEGS-1:0] gate_lo
);

  localparam int unsigned GAP_W = $clog2(DEAD_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DEAD_CYC);

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);

  // R8
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    global_off |=> (gate_hi == '0 && gate_lo == '0));

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg_chk
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  gap <= '0;
      else if (gate_hi[g] || gate_lo[g] || global_off) gap <= '0;
      else if (gap != GAP_MAX)                     gap <= gap + 1'b1;
    end

    // R6
    dead_gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[g]) |-> gap >= GAP_MAX);

    // R6
    dead_gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[g]) |-> gap >= GAP_MAX);

    // R5
    grant_hi_lone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[g]) |-> $past(sync_hi[g] && !sync_lo[g]));

    // R5
    grant_lo_lone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[g]) |-> $past(sync_lo[g] && !sync_hi[g]));

    // R4
    hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi[g] && sync_hi[g] && !global_off) |=> gate_hi[g]);

    // R4
    hold_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_lo[g] && sync_lo[g] && !global_off) |=> gate_lo[g]);

    // R6
    fall_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      leg_fall[g] |=> !(gate_hi[g] || gate_lo[g]));
  end

endmodule

bind gate_interlock gate_interlock_chk #(
  .NUM_LEGS (NUM_LEGS),
  .DEAD_CYC (DEAD_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .global_off (global_off),
  .sync_hi    (sync_hi),
  .sync_lo    (sync_lo),
  .leg_fall   (leg_fall),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo)
);

// File: tb/tb_gate_interlock.sv
module tb_gate_interlock;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 3;
  localparam int DT = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] cmd_hi;
  logic [NL-1:0] cmd_lo;
  logic          global_off;
  logic [NL-1:0] gate_hi;
  logic [NL-1:0] gate_lo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_interlock #(.NUM_LEGS(NL), .DEAD_CYC(DT)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_hi     (cmd_hi),
    .cmd_lo     (cmd_lo),
    .global_off (global_off),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected vector packs {lo[2:0], hi[2:0]}
  task automatic check(input string tag, input logic [2*NL-1:0] expv);
    logic [2*NL-1:0] act;
    act = {gate_lo, gate_hi};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic settle();
    cmd_hi = '0;
    cmd_lo = '0;
    wait_n(3 + DT + 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_hi = '0; cmd_lo = '0; global_off = 1'b0;
    wait_n(3);
    check("R1 reset outputs low", 6'b000_000);

    // R1: release reset with high command present, wait out DT
    rst_n = 1'b1;
    cmd_hi[0] = 1'b1;
    wait_n(DT - 1);
    check("R1 held during post-reset dead time", 6'b000_000);
    wait_n(1);
    check("R1 turn on after post-reset dead time", 6'b000_001);

    // R4: low request while high is on is ignored
    cmd_lo[0] = 1'b1;
    wait_n(10);
    check("R4 late low blocked", 6'b000_001);

    // R6: release high, low takes over after dead time
    cmd_hi[0] = 1'b0;
    wait_n(2);
    check("R6 high still on before fall edge", 6'b000_001);
    wait_n(1);
    check("R6 high off at third edge", 6'b000_000);
    wait_n(DT - 1);
    check("R6 both off before dead time ends", 6'b000_000);
    wait_n(1);
    check("R6 low on after dead time", 6'b001_000);

    // R4: symmetric, high blocked while low on
    cmd_hi[0] = 1'b1;
    wait_n(10);
    check("R4 late high blocked", 6'b001_000);
    cmd_lo[0] = 1'b0;
    wait_n(3 + DT - 1);
    check("R6 low-to-high gap", 6'b000_000);
    wait_n(1);
    check("R6 high on after handover", 6'b000_001);

    // R7: same-side drop and reassert still waits DT
    cmd_hi[0] = 1'b0;
    wait_n(1);
    cmd_hi[0] = 1'b1;
    wait_n(3 + DT - 2);
    check("R7 reassert held off", 6'b000_000);
    wait_n(1);
    check("R7 reassert on after dead time", 6'b000_001);

    // R8: kill
    global_off = 1'b1;
    wait_n(1);
    check("R8 kill clears next edge", 6'b000_000);
    wait_n(5);
    check("R8 kill holds", 6'b000_000);
    global_off = 1'b0;
    wait_n(DT - 1);
    check("R8 dead time after release", 6'b000_000);
    wait_n(1);
    check("R8 on after release dead time", 6'b000_001);
    settle();

    // R3: latency from idle
    cmd_lo[2] = 1'b1;
    wait_n(2);
    check("R3 not yet at second edge", 6'b000_000);
    wait_n(1);
    check("R3 on at third edge", 6'b100_000);
    settle();

    // R5: simultaneous requests
    cmd_hi[1] = 1'b1;
    cmd_lo[1] = 1'b1;
    wait_n(15);
    check("R5 simultaneous both off", 6'b000_000);
    cmd_lo[1] = 1'b0;
    wait_n(2);
    check("R5 still off before third edge", 6'b000_000);
    wait_n(1);
    check("R5 survivor on", 6'b000_010);
    settle();

    // R9 / R2: sweep all command patterns from idle
    for (int p = 0; p < 64; p++) begin
      logic [NL-1:0] h, l;
      h = p[NL-1:0];
      l = p[2*NL-1:NL];
      cmd_hi = h;
      cmd_lo = l;
      wait_n(12);
      check($sformatf("R9 R2 pattern %0d", p), {l & ~h, h & ~l});
      settle();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule